// File: doc/BRIEF.md
# Program Counter with Branch and Jump Selection

This block keeps the fetch address of a simple 32-bit processor and chooses the next one every clock cycle. Each cycle it looks at the instruction word being executed and at the two register values that a conditional branch compares. From these it picks one of three next addresses: the sequential address, a branch target relative to the sequential address, or a jump target inside the current 256 MB region. Alongside the registered fetch address it presents the sequential address, so that later stages can use the return or fall-through address without an adder of their own.

The pipeline gates the unit with an advance enable. When the enable is low the address is held, so that the unit works with stalls. A synchronous active-high reset loads a parameterised start address. Addresses count bytes, and every instruction address is a multiple of four. A start address that is not a multiple of four stops elaboration.

Top module: `pc_sequencer`

## Requirements
- R1: While `rst` is high at a rising clock edge, `pc_q` is loaded with RESET_VEC (default 0x00000000), whatever the value of `adv_en`.
- R2: When `adv_en` is low and `rst` is low at a rising edge, `pc_q` keeps its value for any instruction and any operands.
- R3: When `adv_en` is high and the opcode `instr[31:26]` is not 2, 4 or 5, the next `pc_q` is `pc_q + 4`.
- R4: With opcode 4 (branch-if-equal) and `cmp_a == cmp_b`, the next `pc_q` is `pc_q + 4 + (sign_extend(instr[15:0]) << 2)`. If the operands differ, the next `pc_q` is `pc_q + 4`.
- R5: With opcode 5 (branch-if-not-equal) and `cmp_a != cmp_b`, the next `pc_q` is the same branch target as in R4. If the operands are equal, the next `pc_q` is `pc_q + 4`.
- R6: Branch targets are computed modulo 2^32. A negative offset from a low address wraps to the top of the address space, and offset -1 branches back to the branch itself.
- R7: With opcode 2 (jump), the next `pc_q` is `{pc_q[31:28], instr[25:0], 2'b00}`. The upper four bits come from the current `pc_q`, not from `pc_q + 4`.
- R8: `pc_q[1:0]` is always 0, and `pc_plus4` always equals `pc_q + 4` modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| adv_en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction word being executed |
| cmp_a | input | 32 | First value compared by a branch |
| cmp_b | input | 32 | Second value compared by a branch |
| pc_q | output | 32 | Current fetch address (registered) |
| pc_plus4 | output | 32 | Sequential address pc_q + 4 |

## Verification
The bench sweeps all 64 opcodes, each with equal and with unequal operands. A design that decoded a neighbouring opcode as control flow would jump away from the sequential path, and one that swapped the equality sense would take branches the wrong way. Branch offsets at 0, +1, -1 and both 16-bit extremes show whether the offset is sign-extended, scaled to words and based on PC+4. A design that added the offset to the branch's own address, or that forgot the shift by two, ends one word or a factor of four away. Jumps issued from 0x0FFFFFFC and from 0xFFFFFFFC expose any design that takes the region bits from PC+4. Reset is pulsed while stalled and while advancing, to catch an enable that wrongly gates reset.

// File: rtl/pc_seq_pkg.sv
package pc_seq_pkg;
  localparam int OPC_W  = 6;
  localparam int OFF_W  = 16;
  localparam int JFLD_W = 26;

  localparam logic [OPC_W-1:0] OPC_JMP = 6'd2;
  localparam logic [OPC_W-1:0] OPC_BEQ = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BNE = 6'd5;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2
  } next_sel_e;

  typedef struct packed {
    logic is_beq;
    logic is_bne;
    logic is_jmp;
  } ctl_t;
endpackage

// File: rtl/pc_seq_decode.sv
module pc_seq_decode
  import pc_seq_pkg::*;
(
  input  logic [OPC_W+JFLD_W-1:0] instr,
  output ctl_t                    ctl,
  output logic [OFF_W-1:0]        br_off,
  output logic [JFLD_W-1:0]       jmp_fld
);
  logic [OPC_W-1:0] opc;

  assign opc     = instr[OPC_W+JFLD_W-1 -: OPC_W];
  assign br_off  = instr[OFF_W-1:0];
  assign jmp_fld = instr[JFLD_W-1:0];

  always_comb begin
    ctl        = '0;
    ctl.is_beq = (opc == OPC_BEQ);
    ctl.is_bne = (opc == OPC_BNE);
    ctl.is_jmp = (opc == OPC_JMP);
  end
endmodule

// File: rtl/pc_seq_targets.sv
module pc_seq_targets
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [OFF_W-1:0]  br_off,
  input  logic [JFLD_W-1:0] jmp_fld,
  output logic [XLEN-1:0]   seq_tgt,
  output logic [XLEN-1:0]   br_tgt,
  output logic [XLEN-1:0]   jmp_tgt
);
  localparam int EXT_W = XLEN - OFF_W - 2;
  localparam int RGN_W = XLEN - JFLD_W - 2;

  logic [XLEN-1:0] off_bytes;

  assign off_bytes = {{EXT_W{br_off[OFF_W-1]}}, br_off, 2'b00};
  assign seq_tgt   = pc + XLEN'(4);
  assign br_tgt    = seq_tgt + off_bytes;
  assign jmp_tgt   = {pc[XLEN-1 -: RGN_W], jmp_fld, 2'b00};
endmodule

// File: rtl/pc_seq_select.sv
module pc_seq_select
  import pc_seq_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  ctl_t            ctl,
  input  logic            ops_equal,
  input  logic [XLEN-1:0] seq_tgt,
  input  logic [XLEN-1:0] br_tgt,
  input  logic [XLEN-1:0] jmp_tgt,
  output next_sel_e       sel,
  output logic [XLEN-1:0] next_pc
);
  always_comb begin
    sel = SEL_SEQ;
    if (ctl.is_jmp)
      sel = SEL_JMP;
    else if ((ctl.is_beq && ops_equal) || (ctl.is_bne && !ops_equal))
      sel = SEL_BR;
  end

  always_comb begin
    unique case (sel)
      SEL_BR:  next_pc = br_tgt;
      SEL_JMP: next_pc = jmp_tgt;
      default: next_pc = seq_tgt;
    endcase
  end
endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pc_seq_pkg::*;
#(
  parameter int                 XLEN      = 32,
  parameter logic [XLEN-1:0]    RESET_VEC = '0
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv_en,
  input  logic [XLEN-1:0] instr,
  input  logic [XLEN-1:0] cmp_a,
  input  logic [XLEN-1:0] cmp_b,
  output logic [XLEN-1:0] pc_q,
  output logic [XLEN-1:0] pc_plus4
);
  if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
    $error("pc_sequencer: RESET_VEC must be word aligned");
  end
  if (XLEN != OPC_W + JFLD_W) begin : g_bad_xlen
    $error("pc_sequencer: XLEN must match the instruction word width");
  end

  ctl_t              ctl;
  logic [OFF_W-1:0]  br_off;
  logic [JFLD_W-1:0] jmp_fld;
  logic [XLEN-1:0]   seq_tgt, br_tgt, jmp_tgt, next_pc;
  next_sel_e         sel;

  pc_seq_decode u_dec (
    .instr   (instr),
    .ctl     (ctl),
    .br_off  (br_off),
    .jmp_fld (jmp_fld)
  );

  pc_seq_targets #(.XLEN(XLEN)) u_tgt (
    .pc      (pc_q),
    .br_off  (br_off),
    .jmp_fld (jmp_fld),
    .seq_tgt (seq_tgt),
    .br_tgt  (br_tgt),
    .jmp_tgt (jmp_tgt)
  );

  pc_seq_select #(.XLEN(XLEN)) u_sel (
    .ctl       (ctl),
    .ops_equal (cmp_a == cmp_b),
    .seq_tgt   (seq_tgt),
    .br_tgt    (br_tgt),
    .jmp_tgt   (jmp_tgt),
    .sel       (sel),
    .next_pc   (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= RESET_VEC;
    else if (adv_en)
      pc_q <= {next_pc[XLEN-1:2], 2'b00};
  end

  assign pc_plus4 = seq_tgt;

  // R1: reset loads the start address
  a_r1_reset_vec: assert property (@(posedge clk) rst |=> pc_q == RESET_VEC);

  // R2: a stalled cycle leaves the PC alone
  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    !adv_en |=> $stable(pc_q));

  // R3: a non-control opcode advances to the sequential address
  a_r3_seq: assert property (@(posedge clk) disable iff (rst)
    (adv_en && !ctl.is_beq && !ctl.is_bne && !ctl.is_jmp) |=> pc_q == $past(pc_plus4));

  // R7: a jump stays in the region of the current PC
  a_r7_region: assert property (@(posedge clk) disable iff (rst)
    (adv_en && ctl.is_jmp) |=> pc_q[XLEN-1 -: 4] == $past(pc_q[XLEN-1 -: 4]));

  // R8: the PC stays word aligned
  a_r8_align: assert property (@(posedge clk) disable iff (rst)
    adv_en |=> pc_q[1:0] == 2'b00);
endmodule

// File: tb/tb_pc_sequencer.sv
`timescale 1ns/1ps
module tb_pc_sequencer;
  logic        clk = 1'b0;
  logic        rst;
  logic        adv_en;
  logic [31:0] instr, cmp_a, cmp_b;
  logic [31:0] pc_q, pc_plus4;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  logic [31:0] exp_pc;

  always #4 clk = ~clk;

  pc_sequencer dut (
    .clk(clk), .rst(rst), .adv_en(adv_en), .instr(instr),
    .cmp_a(cmp_a), .cmp_b(cmp_b), .pc_q(pc_q), .pc_plus4(pc_plus4)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] model(input logic [31:0] pc, input logic [31:0] ins,
                                        input logic [31:0] a, input logic [31:0] b);
    logic [5:0]  op   = ins[31:26];
    logic [31:0] seq  = pc + 32'd4;
    logic [31:0] offs = 32'($signed(ins[15:0])) * 32'd4;
    if (op == 6'd2) return {pc[31:28], ins[25:0], 2'b00};
    if (op == 6'd4 && a == b) return seq + offs;
    if (op == 6'd5 && a != b) return seq + offs;
    return seq;
  endfunction

  // called at a falling edge; result checked at the next falling edge
  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic en, input string req);
    instr = ins; cmp_a = a; cmp_b = b; adv_en = en;
    if (en) exp_pc = model(exp_pc, ins, a, b);
    @(negedge clk);
    check(req, pc_q, exp_pc);
    check({req, "/R8"}, pc_plus4, exp_pc + 32'd4);
  endtask

  task automatic do_reset(input logic en, input string req);
    rst = 1'b1; adv_en = en; instr = {6'd2, 26'h155}; cmp_a = '0; cmp_b = '0;
    @(negedge clk);
    rst = 1'b0;
    exp_pc = 32'h0;
    check(req, pc_q, 32'h0);
  endtask

  initial begin
    rst = 1'b1; adv_en = 1'b0; instr = '0; cmp_a = '0; cmp_b = '0; exp_pc = '0;
    @(negedge clk); @(negedge clk);
    do_reset(1'b0, "R1 reset while stalled");

    // R3 / R4 / R5 / R7: sweep every opcode, equal and unequal operands
    for (int op = 0; op < 64; op++) begin
      for (int eq = 0; eq < 2; eq++) begin
        logic [31:0] w = {6'(op), 10'(op * 7), 16'(op * 37 - 900)};
        step(w, 32'h1234, eq ? 32'h1234 : 32'h1235,
             1'b1, op == 2 ? "R7 jump sweep" : (op == 4 ? "R4 beq sweep" :
                               (op == 5 ? "R5 bne sweep" : "R3 sequential sweep")));
      end
    end

    // R2: stall with every kind of instruction
    step({6'd2, 26'h3ABCDEF}, 0, 0, 1'b0, "R2 hold on jump");
    step({6'd4, 10'd0, 16'h0040}, 5, 5, 1'b0, "R2 hold on beq");
    step({6'd0, 26'd0}, 0, 1, 1'b0, "R2 hold on alu op");

    // R4 / R5 / R6 offset corners from a known address
    do_reset(1'b1, "R1 reset while advancing");
    step({6'd4, 10'd0, 16'h0000}, 9, 9, 1'b1, "R4 offset 0 is pc+4");
    step({6'd4, 10'd0, 16'h0001}, 9, 9, 1'b1, "R4 offset +1");
    step({6'd5, 10'd0, 16'hFFFF}, 1, 2, 1'b1, "R6 offset -1 loops to self");
    step({6'd5, 10'd0, 16'h7FFF}, 3, 4, 1'b1, "R5 offset max positive");
    step({6'd4, 10'd0, 16'h8000}, 7, 7, 1'b1, "R6 offset max negative");
    step({6'd5, 10'd0, 16'h0100}, 7, 7, 1'b1, "R5 not taken when equal");
    step({6'd4, 10'd0, 16'h0100}, 7, 8, 1'b1, "R4 not taken when unequal");

    // R6 wrap below zero
    do_reset(1'b0, "R1 reset");
    step({6'd4, 10'd0, 16'hFFFE}, 0, 0, 1'b1, "R6 wrap below zero");
    check("R6 wrap value", pc_q, 32'hFFFF_FFFC);
    step({6'd2, 26'h0000003}, 0, 0, 1'b1, "R7 jump from top region");
    check("R7 top region value", pc_q, 32'hF000_000C);

    // R7: region taken from current PC, not pc+4
    do_reset(1'b0, "R1 reset");
    step({6'd2, 26'h3FF_FFFF}, 0, 0, 1'b1, "R7 jump to region end");
    check("R7 region end value", pc_q, 32'h0FFF_FFFC);
    step({6'd2, 26'h0000005}, 0, 0, 1'b1, "R7 region from current pc");
    check("R7 region from current pc value", pc_q, 32'h0000_0014);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule